// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps an effective address onto a real address through a small set of
block translation entries. It is meant to sit in front of a page-table walker. It
keeps two sets of entries: one set serves instruction fetches and the other serves
every other access. Each entry is a pair of 32-bit words.

The first word of an entry holds the following fields:
- the effective block index;
- a block-length mask, which widens the block by ignoring some low index bits;
- one valid bit for supervisor accesses and one valid bit for user accesses.

The second word holds the real block number and a two-bit protection code.

A lookup request carries an address, a fetch/data flag, a write flag and a user
flag. One cycle later the block returns a registered response: hit, the real page
address, and a verdict. The verdict is either granted or protection fault. A miss
reports neither, so the page-table walk can take over.

Entries are loaded one 32-bit word at a time through a plain write port. The port
names the set, the entry index and which of the two words is written.

Top module: `bat_xlate_top`

## Requirements
- R1: After synchronous reset every entry word in both sets is zero, so every lookup misses. rsp_valid is 0 until a request is made.
- R2: A request sampled with req_valid at a clock edge produces its response on rsp_* at the next edge. rsp_valid is high in exactly the cycles that follow a request cycle. A word written at the same edge as a request is not seen by that request; it is seen by requests from the next edge on.
- R3: An entry takes part in a lookup only if the valid bit for the requester's level is set. For supervisor requests (req_user=0) that is bit 1 of the first word. For user requests (req_user=1) that is bit 0.
- R4: Address bits [31:28] must equal bits [31:28] of the first word.
- R5: Address bits [27:17] are compared with first-word bits [27:17]. Before the compare, the address bits at positions set in the block-length mask are cleared. The mask is first-word bits [12:2] placed at positions [27:17].
- R6: On a hit, rsp_raddr is the OR of four parts, and bits [11:0] are zero. The four parts are:
  - second-word bits [31:28];
  - address bits [27:17] ANDed with the block-length mask;
  - second-word bits [27:17];
  - address bits [16:12].
- R7: A fetch (req_fetch=1) searches only the instruction set. Any other access searches only the data set.
- R8: When several entries match, the one with the lowest index decides the response.
- R9: The protection code is second-word bits [1:0], decoded as follows:
  - 0 allows nothing;
  - 1 and 3 allow read and execute;
  - 2 allows read, write and execute.
  A fetch needs execute, a write needs write, and any other access needs read.
- R10: On a hit, exactly one of rsp_grant and rsp_fault is set, chosen by R9. On a miss, rsp_hit, rsp_grant and rsp_fault are 0 and rsp_raddr is 0.
- R11: A write with wr_en=1 stores wr_data into entry wr_idx. wr_instr=1 selects the instruction set and wr_instr=0 the data set. wr_upper=1 selects the first word and wr_upper=0 the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_instr | input | 1 | 1: instruction set, 0: data set |
| wr_upper | input | 1 | 1: first (index) word, 0: second (real) word |
| wr_idx | input | IDX_W (2) | Entry index |
| wr_data | input | 32 | Word value |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | Instruction fetch |
| req_write | input | 1 | Write access (ignored for fetches) |
| req_user | input | 1 | User level (0 = supervisor) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry matched |
| rsp_raddr | output | 32 | Real page address |
| rsp_grant | output | 1 | Hit and access allowed |
| rsp_fault | output | 1 | Hit and access denied |

## Verification
A corrupted entry word or a wrong set selection shows up on the first lookup that
reaches the affected entry. One cycle after that request, it appears as a flipped
rsp_hit, a wrong rsp_raddr field or a reversed verdict. A broken priority chain is
visible only when two entries overlap, so the stimulus places overlapping blocks
on purpose. Block-length masks are drawn from every width, so that a slip in the
mask alignment changes both the match and the real address within a few lookups.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int WORD_W = 32;

    // Field positions inside the two entry words
    localparam int HI_TOP  = 31;
    localparam int HI_BOT  = 28;
    localparam int LO_TOP  = 27;
    localparam int LO_BOT  = 17;
    localparam int LEN_TOP = 12;
    localparam int LEN_BOT = 2;
    localparam int OFS_TOP = 16;
    localparam int OFS_BOT = 12;
    localparam int SUP_BIT = 1;
    localparam int USR_BIT = 0;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic              hit;
        logic [WORD_W-1:0] raddr;
        logic [1:0]        prot;
    } match_t;

    // Block-length field moved to the positions it masks
    function automatic logic [WORD_W-1:0] len_mask(input logic [WORD_W-1:0] up);
        logic [WORD_W-1:0] m;
        m = '0;
        m[LO_TOP:LO_BOT] = up[LEN_TOP:LEN_BOT];
        return m;
    endfunction

    function automatic perm_t prot_decode(input logic [1:0] code);
        perm_t p;
        unique case (code)
            2'b00:   p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
            2'b10:   p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            default: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        endcase
        return p;
    endfunction

    function automatic logic access_ok(input perm_t p, input logic fetch,
                                       input logic write);
        logic ok;
        if (fetch)      ok = p.ex;
        else if (write) ok = p.wr;
        else            ok = p.rd;
        return ok;
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            wr_instr,
    input  logic                            wr_upper,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic                            sel_instr,
    output logic [NUM_ENT-1:0][WORD_W-1:0]  up_sel,
    output logic [NUM_ENT-1:0][WORD_W-1:0]  lo_sel
);

    logic [NUM_ENT-1:0][WORD_W-1:0] i_up, i_lo, d_up, d_lo;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic hit_idx;
        assign hit_idx = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                i_up[e] <= '0;
                i_lo[e] <= '0;
                d_up[e] <= '0;
                d_lo[e] <= '0;
            end else if (hit_idx) begin
                if (wr_instr &&  wr_upper) i_up[e] <= wr_data;
                if (wr_instr && !wr_upper) i_lo[e] <= wr_data;
                if (!wr_instr &&  wr_upper) d_up[e] <= wr_data;
                if (!wr_instr && !wr_upper) d_lo[e] <= wr_data;
            end
        end

        assign up_sel[e] = sel_instr ? i_up[e] : d_up[e];
        assign lo_sel[e] = sel_instr ? i_lo[e] : d_lo[e];
    end

endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
    import bat_pkg::*;
(
    input  logic [WORD_W-1:0] up_word,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] addr,
    input  logic              user,
    output match_t            res
);

    logic [WORD_W-1:0] msk;
    logic              lvl_ok, hi_eq, lo_eq;
    logic [LO_TOP:LO_BOT] lo_addr;
    logic              unused_fields;

    assign msk     = len_mask(up_word);
    assign lvl_ok  = user ? up_word[USR_BIT] : up_word[SUP_BIT];
    assign hi_eq   = (addr[HI_TOP:HI_BOT] == up_word[HI_TOP:HI_BOT]);
    assign lo_addr = addr[LO_TOP:LO_BOT] & ~msk[LO_TOP:LO_BOT];
    assign lo_eq   = (lo_addr == up_word[LO_TOP:LO_BOT]);

    always_comb begin
        res.hit   = lvl_ok && hi_eq && lo_eq;
        res.prot  = lo_word[1:0];
        res.raddr = '0;
        res.raddr[HI_TOP:HI_BOT]  = lo_word[HI_TOP:HI_BOT];
        res.raddr[LO_TOP:LO_BOT]  = (addr[LO_TOP:LO_BOT] & msk[LO_TOP:LO_BOT])
                                  | lo_word[LO_TOP:LO_BOT];
        res.raddr[OFS_TOP:OFS_BOT] = addr[OFS_TOP:OFS_BOT];
    end

    assign unused_fields = ^{up_word[OFS_TOP:LEN_TOP+1], lo_word[OFS_TOP:2],
                             addr[OFS_BOT-1:0]};

endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  match_t [NUM_ENT-1:0] cand,
    output match_t               win
);

    always_comb begin
        win = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (cand[e].hit) win = cand[e];
        end
    end

endmodule

// File: rtl/bat_xlate_top.sv
module bat_xlate_top
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_instr,
    input  logic              wr_upper,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_fetch,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_raddr,
    output logic              rsp_grant,
    output logic              rsp_fault
);

    logic [NUM_ENT-1:0][WORD_W-1:0] up_sel, lo_sel;
    match_t [NUM_ENT-1:0]           cand;
    match_t                         win;
    perm_t                          perm;
    logic                           ok;

    bat_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_instr (wr_instr),
        .wr_upper (wr_upper),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sel_instr(req_fetch),
        .up_sel   (up_sel),
        .lo_sel   (lo_sel)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        bat_entry_cmp u_cmp (
            .up_word(up_sel[e]),
            .lo_word(lo_sel[e]),
            .addr   (req_addr),
            .user   (req_user),
            .res    (cand[e])
        );
    end

    bat_prio_sel #(.NUM_ENT(NUM_ENT)) u_prio (
        .cand(cand),
        .win (win)
    );

    assign perm = prot_decode(win.prot);
    assign ok   = access_ok(perm, req_fetch, req_write);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_raddr <= '0;
            rsp_grant <= 1'b0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= win.hit;
                rsp_raddr <= win.raddr;
                rsp_grant <= win.hit && ok;
                rsp_fault <= win.hit && !ok;
            end
        end
    end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_raddr,
    input logic        rsp_grant,
    input logic        rsp_fault
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_grant && rsp_fault));

    // R10
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (!rsp_grant && !rsp_fault && rsp_raddr == 32'h0));

    // R10
    hit_has_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_grant || rsp_fault));

    // R6
    page_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |->
            (rsp_raddr[16:12] == $past(req_addr[16:12]) && rsp_raddr[11:0] == 12'h0));

endmodule

bind bat_xlate_top bat_xlate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_raddr(rsp_raddr),
    .rsp_grant(rsp_grant),
    .rsp_fault(rsp_fault)
);

// File: tb/sim_bat_xlate_top.sv
module sim_bat_xlate_top;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_instr = 1'b0, wr_upper = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_grant, rsp_fault;
    logic [31:0] rsp_raddr;

    int total = 0;
    int bad   = 0;

    // model storage: [set][entry], set 1 = instruction
    logic [31:0] m_up [2][N];
    logic [31:0] m_lo [2][N];

    always #5 clk = ~clk;

    bat_xlate_top #(.NUM_ENT(N)) u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_instr(wr_instr), .wr_upper(wr_upper),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_raddr(rsp_raddr),
        .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
    );

    // expected {hit, grant, fault, raddr}
    function automatic logic [34:0] model(input bit f, input bit w, input bit u,
                                          input logic [31:0] a);
        int s;
        s = f ? 1 : 0;
        for (int e = 0; e < N; e++) begin
            logic [31:0] up, lo, bl, ra;
            bit v, rd, wrr, ex, ok;
            up = m_up[s][e];
            lo = m_lo[s][e];
            bl = (up & 32'h0000_1FFC) << 15;
            v  = u ? up[0] : up[1];
            if (v && ((a & 32'hF000_0000) == (up & 32'hF000_0000)) &&
                (((a & 32'h0FFE_0000) & ~bl) == (up & 32'h0FFE_0000))) begin
                ra = (lo & 32'hF000_0000) | (a & 32'h0FFE_0000 & bl) |
                     (lo & 32'h0FFE_0000) | (a & 32'h0001_F000);
                rd  = (lo[1:0] != 2'd0);
                ex  = rd;
                wrr = (lo[1:0] == 2'd2);
                ok  = f ? ex : (w ? wrr : rd);
                return {1'b1, ok, !ok, ra};
            end
        end
        return 35'd0;
    endfunction

    task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual hit=%0b grant=%0b fault=%0b raddr=%08h expected hit=%0b grant=%0b fault=%0b raddr=%08h",
                     tag, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input bit ins, input bit upw, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_instr = ins; wr_upper = upw;
        wr_idx = 2'(idx); wr_data = d;
        if (upw) m_up[ins ? 1 : 0][idx] = d;
        else     m_lo[ins ? 1 : 0][idx] = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic look(input string tag, input bit f, input bit w, input bit u,
                        input logic [31:0] a);
        logic [34:0] exp;
        exp = model(f, w, u, a);
        @(negedge clk);
        req_valid = 1'b1; req_fetch = f; req_write = w; req_user = u; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_bit({tag, " valid"}, rsp_valid, 1'b1);
        check(tag, {rsp_hit, rsp_grant, rsp_fault, rsp_raddr}, exp);
    endtask

    task automatic random_entry(input bit ins, input int idx);
        logic [31:0] bl, up;
        int k;
        k  = $urandom_range(0, 11);
        bl = ((32'd1 << k) - 1) << 17;
        up = ($urandom & 32'hFFFE_0000) & ~bl;
        up = up | (bl >> 15) | ($urandom & 32'h0001_E003);
        wr(ins, 1'b1, idx, up);
        wr(ins, 1'b0, idx, $urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [34:0] e_old;
        void'($urandom(32'd1234));
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < N; e++) begin
                m_up[s][e] = '0;
                m_lo[s][e] = '0;
            end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_bit("R1 no response after reset", rsp_valid, 1'b0);
        look("R1 empty data set", 1'b0, 1'b0, 1'b0, 32'h0000_0000);
        look("R1 empty instr set", 1'b1, 1'b0, 1'b1, 32'h1234_5678);

        // R11 / R7: load instruction entry 0 only
        wr(1'b1, 1'b1, 0, 32'h1234_0003);
        wr(1'b1, 1'b0, 0, 32'h8000_0002);
        look("R7 data side misses instr entry", 1'b0, 1'b0, 1'b0, 32'h1234_5678);
        look("R11 R7 fetch hits instr entry", 1'b1, 1'b0, 1'b0, 32'h1234_5678);
        // R4: top nibble differs
        look("R4 high index mismatch", 1'b1, 1'b0, 1'b0, 32'h5234_5678);
        // R2: idle cycle, no response
        @(negedge clk);
        check_bit("R2 idle gives no rsp_valid", rsp_valid, 1'b0);

        // R3: data entry 1 supervisor only
        wr(1'b0, 1'b1, 1, 32'hA000_0002);
        wr(1'b0, 1'b0, 1, 32'h3000_0002);
        look("R3 user rejected", 1'b0, 1'b0, 1'b1, 32'hA000_1000);
        look("R3 supervisor accepted", 1'b0, 1'b1, 1'b0, 32'hA000_1000);

        // R5 / R6: data entry 0 with 3-bit block length, bits 19:17 masked
        wr(1'b0, 1'b1, 0, 32'h4060_001F);
        wr(1'b0, 1'b0, 0, 32'h7120_0001);
        look("R5 R6 masked bit differs", 1'b0, 1'b0, 1'b1, 32'h4064_A000);
        look("R5 unmasked bit differs", 1'b0, 1'b0, 1'b1, 32'h4070_0000);

        // R8: entries 2 and 3 overlap, entry 2 must win
        wr(1'b0, 1'b1, 3, 32'hC000_0003);
        wr(1'b0, 1'b0, 3, 32'h1000_0002);
        wr(1'b0, 1'b1, 2, 32'hC000_0003);
        wr(1'b0, 1'b0, 2, 32'h2000_0000);
        look("R8 lower index wins", 1'b0, 1'b0, 1'b0, 32'hC000_3000);

        // R9 / R10: protection sweep on instr entry 1
        wr(1'b1, 1'b1, 1, 32'hE000_0003);
        for (int pp = 0; pp < 4; pp++) begin
            wr(1'b1, 1'b0, 1, 32'h0200_0000 | 32'(pp));
            wr(1'b0, 1'b1, 1, 32'hE000_0003);
            wr(1'b0, 1'b0, 1, 32'h0200_0000 | 32'(pp));
            look($sformatf("R9 R10 fetch pp=%0d", pp), 1'b1, 1'b0, 1'b0, 32'hE000_5000);
            look($sformatf("R9 R10 read pp=%0d", pp),  1'b0, 1'b0, 1'b0, 32'hE000_5000);
            look($sformatf("R9 R10 write pp=%0d", pp), 1'b0, 1'b1, 1'b0, 32'hE000_5000);
        end

        // R2: write at the same edge as a lookup is not seen by it
        e_old = model(1'b0, 1'b0, 1'b0, 32'hE000_5000);
        @(negedge clk);
        wr_en = 1'b1; wr_instr = 1'b0; wr_upper = 1'b1; wr_idx = 2'd1; wr_data = 32'h0;
        req_valid = 1'b1; req_fetch = 1'b0; req_write = 1'b0; req_user = 1'b0;
        req_addr = 32'hE000_5000;
        m_up[0][1] = 32'h0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R2 same-edge write unseen", {rsp_hit, rsp_grant, rsp_fault, rsp_raddr}, e_old);
        look("R2 write seen next lookup", 1'b0, 1'b0, 1'b0, 32'hE000_5000);

        // random phase
        for (int r = 0; r < 6; r++) begin
            for (int s = 0; s < 2; s++)
                for (int e = 0; e < N; e++) random_entry(s[0], e);
            for (int t = 0; t < 60; t++) begin
                bit f, w, u;
                int j;
                logic [31:0] up, bl, a;
                f = $urandom_range(0, 1);
                w = $urandom_range(0, 1);
                u = $urandom_range(0, 1);
                j = $urandom_range(0, N - 1);
                up = m_up[f ? 1 : 0][j];
                bl = (up & 32'h0000_1FFC) << 15;
                if ($urandom_range(0, 3) == 0) a = $urandom;
                else a = (up & 32'hF000_0000) | ((up & 32'h0FFE_0000) & ~bl) |
                         ($urandom & (bl | 32'h0001_FFFF));
                look("R3 R4 R5 R6 R7 R8 R9 R10 random", f, w, u, a);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule